// File: doc/BRIEF.md
# Interrupt Status, Mask and Coalescing Controller

This block holds the interrupt cause register and the interrupt enable mask of a network interface, and drives one level-sensitive interrupt line toward the host. Event sources raise cause bits through a post strobe. The host reads the cause register to clear it, writes it to clear selected bits, rewrites the mask, and turns a global enable on or off. All of these host operations arrive as single-cycle strobes.

Causes in an urgent group reach the host at once. All other causes are coalesced behind one down-counting deadline, and the earliest requested deadline wins. Two watermark causes are qualified by queue history. The receive-high cause needs a prior "receive queue drained" event. The transmit-low cause needs a prior "transmit queue filled" event. Both history flags are consumed by every post. Once the line is up it stays up until the masked causes become zero or the enable is dropped.

Top module: `irq_coalescer`

## Requirements
- R1: After reset, irq, status_q, enabled and err are 0, and mask_q equals MASK_RST (default 0x47: bits 0, 1, 2 and 6).
- R2: A post ORs post_bits into status_q on the next edge. If the block is enabled and a masked cause is in the urgent group (bit 0 by default), irq is 1 on the edge that samples the post.
- R3: When a post carries only non-urgent masked causes, irq rises delay_cfg edges after the edge that samples the post. A delay_cfg of 0 behaves like an urgent post.
- R4: One deadline is kept. A new post whose delay is no greater than the remaining count reloads the deadline. A post with a longer delay is absorbed, and the line rises at the older, earlier deadline.
- R5: The receive-high cause (bit 2) counts toward the line only when the drained flag is set. rx_drained sets the flag, and any post clears it. When the flag is clear, the cause is still stored but does not raise irq.
- R6: The transmit-low cause (bit 6) counts toward the line only when the filled flag is set. tx_filled sets the flag, and any post clears it.
- R7: rd_status clears every status bit. wr_status clears only the bits that are 1 in wr_data.
- R8: Whenever status_q AND mask_q becomes zero, irq drops and any armed deadline is cancelled. A cancelled deadline never raises irq later.
- R9: Writing a mask different from the current one re-evaluates at once. irq is 1 on that edge if the new masked status is nonzero and enabled is 1, and 0 if the new masked status is zero.
- R10: While enabled is 0, posts update status but never raise irq. Setting the enable raises irq at once if the masked status is nonzero. Clearing it drops irq.
- R11: Bits 31..28 are reserved. A post or status write that touches them pulses err for exactly one cycle, and no reserved bit is ever stored.
- R12: While irq is 1, a later deadline expiring leaves it at 1. Only R8 or R10 lowers it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_stb | input | 1 | Event post strobe |
| post_bits | input | W | Cause bits to post |
| rx_drained | input | 1 | Receive queue became empty |
| tx_filled | input | 1 | Transmit queue became full |
| rd_status | input | 1 | Host read of the status register (clears it) |
| wr_status | input | 1 | Host write-one-to-clear of status |
| wr_mask | input | 1 | Host mask write |
| wr_data | input | W | Host write data for status or mask |
| wr_enable | input | 1 | Global enable write strobe |
| enable_val | input | 1 | Value written to the global enable |
| delay_cfg | input | DW | Coalescing delay in cycles |
| irq | output | 1 | Level interrupt to the host |
| status_q | output | W | Current status register |
| mask_q | output | W | Current mask register |
| enabled | output | 1 | Global enable state |
| err | output | 1 | One-cycle reserved-bit error pulse |

## Verification
The bound checker watches invariants on every cycle. These are: irq never stands without enable and a nonzero masked status, reserved bits are never stored and always produce the error pulse, a status read empties the register, posted bits land, an asserted line holds through unrelated cycles, and a changed mask with live causes raises the line. Timing properties can only be shown by the bench scenarios, because the delay window depends on a runtime count. These cover the exact rise cycle of delayed posts, reloading versus absorbing the deadline, consumption of the drained and filled history flags, and proof that a cancelled deadline never fires.

// File: rtl/irq_coalescer.sv
module irq_coalescer #(
  parameter int W = 32,
  parameter int DW = 16,
  parameter int RXHI_BIT = 2,
  parameter int TXLO_BIT = 6,
  parameter logic [W-1:0] URGENT = 32'h0000_0001,
  parameter logic [W-1:0] RSVD = 32'hF000_0000,
  parameter logic [W-1:0] MASK_RST = 32'h0000_0047
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          post_stb,
  input  logic [W-1:0]  post_bits,
  input  logic          rx_drained,
  input  logic          tx_filled,
  input  logic          rd_status,
  input  logic          wr_status,
  input  logic          wr_mask,
  input  logic [W-1:0]  wr_data,
  input  logic          wr_enable,
  input  logic          enable_val,
  input  logic [DW-1:0] delay_cfg,
  output logic          irq,
  output logic [W-1:0]  status_q,
  output logic [W-1:0]  mask_q,
  output logic          enabled,
  output logic          err
);

  logic          pend, armed, rx_mt, tx_fl;
  logic [DW-1:0] cnt;
  logic [W-1:0]  set_bits, clr_bits, stat_n, mask_n, live, cand;
  logic          en_n, post_hit, post_now, post_late;
  logic          mask_kick, en_kick, expire, kill, fire, load, rsvd_hit;

  assign rsvd_hit = (post_stb && |(post_bits & RSVD)) || (wr_status && |(wr_data & RSVD));
  assign set_bits = post_stb ? (post_bits & ~RSVD) : '0;
  assign clr_bits = rd_status ? '1 : (wr_status ? (wr_data & ~RSVD) : '0);
  assign stat_n   = (status_q | set_bits) & ~clr_bits;
  assign mask_n   = wr_mask ? wr_data : mask_q;
  assign en_n     = wr_enable ? enable_val : enabled;
  assign live     = stat_n & mask_n;

  always_comb begin
    cand = live;
    if (!rx_mt) cand[RXHI_BIT] = 1'b0;
    if (!tx_fl) cand[TXLO_BIT] = 1'b0;
  end

  assign post_hit  = post_stb && enabled && |cand;
  assign post_now  = post_hit && (|(cand & URGENT) || delay_cfg == '0);
  assign post_late = post_hit && !post_now;
  assign mask_kick = wr_mask && (wr_data != mask_q) && enabled && |live;
  assign en_kick   = wr_enable && enable_val && !enabled && |live;
  assign expire    = armed && cnt == DW'(1);
  assign kill      = !en_n || ~|live;
  assign fire      = post_now || mask_kick || en_kick || expire;
  assign load      = post_late && (!armed || delay_cfg <= cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= MASK_RST;
      enabled  <= 1'b0;
      rx_mt    <= 1'b0;
      tx_fl    <= 1'b0;
      err      <= 1'b0;
    end else begin
      status_q <= stat_n;
      mask_q   <= mask_n;
      enabled  <= en_n;
      rx_mt    <= (rx_mt && !post_stb) || rx_drained;
      tx_fl    <= (tx_fl && !post_stb) || tx_filled;
      err      <= rsvd_hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      pend  <= 1'b0;
      armed <= 1'b0;
      cnt   <= '0;
    end else if (fire) begin
      pend  <= 1'b1;
      armed <= 1'b0;
    end else if (load) begin
      armed <= 1'b1;
      cnt   <= delay_cfg;
    end else if (armed) begin
      cnt   <= cnt - DW'(1);
    end
  end

  assign irq = pend;

endmodule

module irq_coalescer_chk #(
  parameter int W = 32,
  parameter logic [W-1:0] RSVD = 32'hF000_0000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         post_stb,
  input logic [W-1:0] post_bits,
  input logic         rd_status,
  input logic         wr_status,
  input logic         wr_mask,
  input logic [W-1:0] wr_data,
  input logic         wr_enable,
  input logic         irq,
  input logic [W-1:0] status_q,
  input logic [W-1:0] mask_q,
  input logic         enabled,
  input logic         err
);

  assert_line_needs_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (enabled && |(status_q & mask_q)));

  assert_line_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |-> !irq);

  assert_rsvd_never_stored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ~|(status_q & RSVD));

  assert_rsvd_flags_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (post_stb && |(post_bits & RSVD)) |=> err);

  assert_read_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |=> status_q == '0);

  assert_post_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (post_stb && !rd_status && !wr_status) |=>
      (status_q & $past(post_bits & ~RSVD)) == $past(post_bits & ~RSVD));

  assert_line_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rd_status && !wr_status && !wr_mask && !wr_enable) |=> irq);

  assert_mask_kick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mask && !rd_status && !wr_status && !wr_enable && enabled &&
     wr_data != mask_q && |(status_q & wr_data)) |=> irq);

endmodule

bind irq_coalescer irq_coalescer_chk #(.W(W), .RSVD(RSVD)) u_chk (
  .clk(clk), .rst_n(rst_n), .post_stb(post_stb), .post_bits(post_bits),
  .rd_status(rd_status), .wr_status(wr_status), .wr_mask(wr_mask),
  .wr_data(wr_data), .wr_enable(wr_enable), .irq(irq), .status_q(status_q),
  .mask_q(mask_q), .enabled(enabled), .err(err)
);

// File: tb/sim_irq_coalescer.sv
`timescale 1ns/1ps
module sim_irq_coalescer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        post_stb = 1'b0, rx_drained = 1'b0, tx_filled = 1'b0;
  logic        rd_status = 1'b0, wr_status = 1'b0, wr_mask = 1'b0;
  logic        wr_enable = 1'b0, enable_val = 1'b0;
  logic [31:0] post_bits = '0, wr_data = '0;
  logic [15:0] delay_cfg = '0;
  logic        irq, enabled, err;
  logic [31:0] status_q, mask_q;

  int checks = 0, fails = 0;
  bit done = 0;

  typedef struct {
    logic        irq;
    logic [31:0] st;
    logic [31:0] mk;
    logic        er;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  irq_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .post_stb(post_stb), .post_bits(post_bits),
    .rx_drained(rx_drained), .tx_filled(tx_filled), .rd_status(rd_status),
    .wr_status(wr_status), .wr_mask(wr_mask), .wr_data(wr_data),
    .wr_enable(wr_enable), .enable_val(enable_val), .delay_cfg(delay_cfg),
    .irq(irq), .status_q(status_q), .mask_q(mask_q), .enabled(enabled), .err(err)
  );

  initial forever begin
    exp_t it;
    wait (sb.size() != 0);
    it = sb.pop_front();
    checks++;
    if (irq !== it.irq || status_q !== it.st || mask_q !== it.mk || err !== it.er) begin
      fails++;
      $display("FAIL %s: got irq=%0b st=%h mk=%h err=%0b, want irq=%0b st=%h mk=%h err=%0b",
               it.tag, irq, status_q, mask_q, err, it.irq, it.st, it.mk, it.er);
    end
  end

  task automatic expect_now(input logic i, input logic [31:0] s, input logic [31:0] m,
                            input logic e, input string tag);
    exp_t it;
    it.irq = i; it.st = s; it.mk = m; it.er = e; it.tag = tag;
    sb.push_back(it);
    #0.1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic post(input logic [31:0] b);
    post_stb = 1'b1; post_bits = b; @(negedge clk); post_stb = 1'b0; post_bits = '0;
  endtask

  task automatic rd();
    rd_status = 1'b1; @(negedge clk); rd_status = 1'b0;
  endtask

  task automatic wrs(input logic [31:0] d);
    wr_status = 1'b1; wr_data = d; @(negedge clk); wr_status = 1'b0; wr_data = '0;
  endtask

  task automatic wrm(input logic [31:0] d);
    wr_mask = 1'b1; wr_data = d; @(negedge clk); wr_mask = 1'b0; wr_data = '0;
  endtask

  task automatic wen(input logic v);
    wr_enable = 1'b1; enable_val = v; @(negedge clk); wr_enable = 1'b0;
  endtask

  task automatic drained();
    rx_drained = 1'b1; @(negedge clk); rx_drained = 1'b0;
  endtask

  task automatic filled();
    tx_filled = 1'b1; @(negedge clk); tx_filled = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout want finish");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  localparam logic [31:0] M = 32'h47;

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    expect_now(0, 0, M, 0, "R1 reset state");
    if (enabled !== 1'b0) begin
      fails++; $display("FAIL R1 enable: got %0b want 0", enabled);
    end
    checks++;
    wen(1);
    expect_now(0, 0, M, 0, "R10 enable with no cause");

    delay_cfg = 16'd5;
    post(32'h1);
    expect_now(1, 32'h1, M, 0, "R2 urgent post immediate");
    rd();
    expect_now(0, 0, M, 0, "R7 read clears all");

    delay_cfg = 16'd4;
    post(32'h2);
    expect_now(0, 32'h2, M, 0, "R3 delayed not yet");
    idle(3);
    expect_now(0, 32'h2, M, 0, "R3 one cycle before deadline");
    idle(1);
    expect_now(1, 32'h2, M, 0, "R3 rises at deadline");
    wrs(32'h2);
    expect_now(0, 0, M, 0, "R7 write clears bit");

    delay_cfg = 16'd10;
    post(32'h2);
    idle(3);
    delay_cfg = 16'd2;
    post(32'h2);
    expect_now(0, 32'h2, M, 0, "R4 reload pending");
    idle(1);
    expect_now(0, 32'h2, M, 0, "R4 reload one before");
    idle(1);
    expect_now(1, 32'h2, M, 0, "R4 earlier deadline wins");
    rd();

    delay_cfg = 16'd3;
    post(32'h2);
    idle(1);
    delay_cfg = 16'd20;
    post(32'h2);
    expect_now(0, 32'h2, M, 0, "R4 absorb pending");
    idle(1);
    expect_now(1, 32'h2, M, 0, "R4 longer post absorbed");
    rd();

    delay_cfg = 16'd0;
    post(32'h2);
    expect_now(1, 32'h2, M, 0, "R3 zero delay immediate");
    delay_cfg = 16'd2;
    post(32'h2);
    idle(2);
    expect_now(1, 32'h2, M, 0, "R12 line holds through expiry");
    rd();
    expect_now(0, 0, M, 0, "R8 drop on clear");

    delay_cfg = 16'd0;
    post(32'h4);
    expect_now(0, 32'h4, M, 0, "R5 rx-high suppressed without drain");
    drained();
    post(32'h4);
    expect_now(1, 32'h4, M, 0, "R5 rx-high after drain");
    rd();
    post(32'h4);
    expect_now(0, 32'h4, M, 0, "R5 drain flag consumed");
    rd();
    drained();
    post(32'h8);
    post(32'h4);
    expect_now(0, 32'hC, M, 0, "R5 flag consumed by other post");
    rd();

    post(32'h40);
    expect_now(0, 32'h40, M, 0, "R6 tx-low suppressed without fill");
    filled();
    post(32'h40);
    expect_now(1, 32'h40, M, 0, "R6 tx-low after fill");
    rd();

    delay_cfg = 16'd10;
    post(32'h8);
    expect_now(0, 32'h8, M, 0, "R9 unmasked cause silent");
    wrm(32'h4F);
    expect_now(1, 32'h8, 32'h4F, 0, "R9 mask write raises at once");
    wrm(M);
    expect_now(0, 32'h8, M, 0, "R9 mask write drops");
    rd();

    wen(0);
    delay_cfg = 16'd0;
    post(32'h1);
    expect_now(0, 32'h1, M, 0, "R10 disabled post ignored");
    wen(1);
    expect_now(1, 32'h1, M, 0, "R10 enable reposts");
    wen(0);
    expect_now(0, 32'h1, M, 0, "R10 disable drops");
    rd();
    wen(1);
    expect_now(0, 0, M, 0, "R10 enable with empty status");

    post(32'h3);
    expect_now(1, 32'h3, M, 0, "R2 multi-bit post");
    wrs(32'h1);
    expect_now(1, 32'h2, M, 0, "R7 partial clear keeps line");
    wrs(32'h2);
    expect_now(0, 0, M, 0, "R8 last bit clear drops");

    delay_cfg = 16'd3;
    post(32'h2);
    idle(1);
    wrs(32'h2);
    idle(3);
    expect_now(0, 0, M, 0, "R8 cancelled deadline never fires");

    post(32'h1000_0000);
    expect_now(0, 0, M, 1, "R11 reserved post flags err");
    idle(1);
    expect_now(0, 0, M, 0, "R11 err is one cycle");
    wrs(32'h2000_0000);
    expect_now(0, 0, M, 1, "R11 reserved write flags err");

    wait (sb.size() == 0);
    #1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule